// File: doc/BRIEF.md
# CPU Bank Mapper

This block sits between an 8-bit CPU bus and the program-side memories of a console cartridge. It splits the 64 KB address space into 256 slots of 256 bytes. Each slot points into program ROM, work RAM or battery-backed save RAM, and each slot carries its own read and write rights. A programming port lets the mapper logic point a range of slots at a numbered page of one memory. The block wraps the page number, fills large ranges with consecutive pages, and works out the byte offsets on its own.

Writes inside a configurable register window go to the register logic and not to memory. An optional bus-conflict mode ANDs the written byte with the byte that the slot currently presents, as a ROM on a shared data bus would. Reads from slots with no read right return the last value that the data bus carried.

Top module: `cpu_bank_map`

## Requirements
- R1: A read outside the register window, from a slot whose access field has bit 0 (read) set, returns the byte of the slot's memory at byte offset slot_offset*256 + cpu_addr[7:0]. Type codes are 0 = ROM, 1 = work RAM and 2 = save RAM. Access bit 0 is read and bit 1 is write.
- R2: A mapping request leaves the table unchanged if map_start[7:0] is not 0x00, if map_end[7:0] is not 0xFF, if map_start is above 0xFF00, if map_end is not above map_start, if the type code is 3, or if the chosen memory has no pages.
- R3: A negative page number p selects page count + p, for p in -count..-1. A non-negative page number selects p modulo the page count, and the page count need not be a power of two.
- R4: If a range covers at least one page, whole pages fill it from its first slot, with the page number advancing by one per page and wrapping to 0 after the last page. Slots past the last whole page keep their old entries. A range shorter than one page maps the start of the selected page.
- R5: With map_dflt high, ROM slots get read-only access and RAM slots get read/write access. With map_dflt low, map_acc is stored as given.
- R6: A read from a slot without read right returns the last value on the data bus: the last read result or the last write data.
- R7: A write outside the register window asserts wram_we or sram_we, at the slot's address, only when the slot has the write right and that memory type. At most one of the two is asserted.
- R8: A write inside [REG_LO, REG_HI] pulses reg_wr and writes no memory. With cfg_bus_conflict high, reg_wdata is the write data ANDed with the slot's byte (0xFF if the slot is unreadable), and bus_conflict is raised when the two differ. With it low, the data passes unchanged.
- R9: With cfg_reg_read high, a read inside the register window pulses reg_rd and returns reg_rdata. With it low, the read follows R1/R6.
- R10: The ROM page size is clamped to the ROM size, so a ROM smaller than one page repeats across the whole mapped range.
- R11: After reset, slots 0x60-0x7F map save RAM read/write if HAS_BATTERY and save RAM exist, or else work RAM if it exists. Their offsets run linearly and wrap at the memory size. All other slots have no access.
- R12: A table update takes effect on the cycle after map_we. A bus access in the same cycle as map_we sees the old mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| cfg_bus_conflict | input | 1 | Enables ANDing of register writes with the slot byte |
| cfg_reg_read | input | 1 | Enables register reads |
| reg_rd | output | 1 | Register read strobe |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Data delivered to the register logic |
| reg_rdata | input | 8 | Register read data |
| bus_conflict | output | 1 | Register write data differed from the slot byte |
| map_we | input | 1 | Mapping request strobe |
| map_start | input | 16 | First address of the range |
| map_end | input | 16 | Last address of the range |
| map_type | input | 2 | Memory type code |
| map_page | input | PAGE_W | Signed page number |
| map_dflt | input | 1 | Use the default access for the type |
| map_acc | input | 2 | Explicit access (bit 0 read, bit 1 write) |
| rom_addr | output | ROM_AW | ROM byte address |
| rom_rdata | input | 8 | ROM data (combinational) |
| wram_addr | output | WRAM_AW | Work RAM byte address |
| wram_wdata | output | 8 | Work RAM write data |
| wram_we | output | 1 | Work RAM write enable |
| wram_rdata | input | 8 | Work RAM data (combinational) |
| sram_addr | output | SRAM_AW | Save RAM byte address |
| sram_wdata | output | 8 | Save RAM write data |
| sram_we | output | 1 | Save RAM write enable |
| sram_rdata | input | 8 | Save RAM data (combinational) |

## Verification
The assertions assume that cpu_rd and cpu_wr are never high together. They also assume that the memories answer combinationally in the same cycle. The bench raises one strobe per transaction and returns it low before the next one. Its memory models answer without delay, and negative page numbers stay within minus the page count. This keeps the write-enable and register-window properties meaningful, and it means every read sweep sees a well-defined open-bus value.

// File: rtl/cpu_bank_map.sv
module cpu_bank_map #(
  parameter int ROM_BYTES   = 40960,
  parameter int ROM_PAGE    = 8192,
  parameter int WRAM_BYTES  = 8192,
  parameter int WRAM_PAGE   = 8192,
  parameter int SRAM_BYTES  = 24576,
  parameter int SRAM_PAGE   = 8192,
  parameter int HAS_BATTERY = 1,
  parameter int PAGE_W      = 8,
  parameter logic [15:0] REG_LO = 16'h8000,
  parameter logic [15:0] REG_HI = 16'hFFFF,
  localparam int ROM_AW  = (ROM_BYTES  > 256) ? $clog2(ROM_BYTES)  : 8,
  localparam int WRAM_AW = (WRAM_BYTES > 256) ? $clog2(WRAM_BYTES) : 8,
  localparam int SRAM_AW = (SRAM_BYTES > 256) ? $clog2(SRAM_BYTES) : 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [15:0]              cpu_addr,
  input  logic                     cpu_rd,
  input  logic                     cpu_wr,
  input  logic [7:0]               cpu_wdata,
  output logic [7:0]               cpu_rdata,
  input  logic                     cfg_bus_conflict,
  input  logic                     cfg_reg_read,
  output logic                     reg_rd,
  output logic                     reg_wr,
  output logic [7:0]               reg_wdata,
  input  logic [7:0]               reg_rdata,
  output logic                     bus_conflict,
  input  logic                     map_we,
  input  logic [15:0]              map_start,
  input  logic [15:0]              map_end,
  input  logic [1:0]               map_type,
  input  logic signed [PAGE_W-1:0] map_page,
  input  logic                     map_dflt,
  input  logic [1:0]               map_acc,
  output logic [ROM_AW-1:0]        rom_addr,
  input  logic [7:0]               rom_rdata,
  output logic [WRAM_AW-1:0]       wram_addr,
  output logic [7:0]               wram_wdata,
  output logic                     wram_we,
  input  logic [7:0]               wram_rdata,
  output logic [SRAM_AW-1:0]       sram_addr,
  output logic [7:0]               sram_wdata,
  output logic                     sram_we,
  input  logic [7:0]               sram_rdata
);

  localparam int ROM_PE  = (ROM_PAGE  < ROM_BYTES)  ? ROM_PAGE  : ROM_BYTES;
  localparam int WRAM_PE = (WRAM_PAGE < WRAM_BYTES) ? WRAM_PAGE : WRAM_BYTES;
  localparam int SRAM_PE = (SRAM_PAGE < SRAM_BYTES) ? SRAM_PAGE : SRAM_BYTES;
  localparam int ROM_LG  = (ROM_PE  >= 512) ? $clog2(ROM_PE / 256)  : 0;
  localparam int WRAM_LG = (WRAM_PE >= 512) ? $clog2(WRAM_PE / 256) : 0;
  localparam int SRAM_LG = (SRAM_PE >= 512) ? $clog2(SRAM_PE / 256) : 0;
  localparam int ROM_CNT  = (ROM_PE  == 0) ? 0 : ROM_BYTES  / ROM_PE;
  localparam int WRAM_CNT = (WRAM_PE == 0) ? 0 : WRAM_BYTES / WRAM_PE;
  localparam int SRAM_CNT = (SRAM_PE == 0) ? 0 : SRAM_BYTES / SRAM_PE;
  localparam int ROM_SL  = ROM_BYTES  / 256;
  localparam int WRAM_SL = WRAM_BYTES / 256;
  localparam int SRAM_SL = SRAM_BYTES / 256;
  localparam int MAX_SL  = (ROM_SL > WRAM_SL) ? ((ROM_SL > SRAM_SL) ? ROM_SL : SRAM_SL)
                                              : ((WRAM_SL > SRAM_SL) ? WRAM_SL : SRAM_SL);
  localparam int OFF_W   = (MAX_SL > 2) ? $clog2(MAX_SL) : 1;
  localparam bit USE_SAV = (HAS_BATTERY != 0) && (SRAM_BYTES > 0);
  localparam bit RST_EN  = USE_SAV || (WRAM_BYTES > 0);
  localparam logic [1:0] RST_TYPE = USE_SAV ? 2'd2 : 2'd1;
  localparam int RST_SL0 = USE_SAV ? SRAM_SL : WRAM_SL;
  localparam int RST_SL  = (RST_SL0 == 0) ? 1 : RST_SL0;

  localparam logic [1:0] ACC_NONE = 2'b00;
  localparam logic [1:0] ACC_RO   = 2'b01;
  localparam logic [1:0] ACC_RW   = 2'b11;

  logic [1:0]       t_type [256];
  logic [1:0]       t_acc  [256];
  logic [OFF_W-1:0] t_off  [256];

  logic             n_hit [256];
  logic [OFF_W-1:0] n_off [256];

  int         cnt_i, lg_i, spp_i, start_i, nsl_i, limit_i, p0;
  logic [1:0] dflt_acc, acc_w;
  logic       ok_req;

  always_comb begin
    cnt_i    = 0;
    lg_i     = 0;
    dflt_acc = ACC_RW;
    case (map_type)
      2'd0: begin cnt_i = ROM_CNT;  lg_i = ROM_LG;  dflt_acc = ACC_RO; end
      2'd1: begin cnt_i = WRAM_CNT; lg_i = WRAM_LG; end
      2'd2: begin cnt_i = SRAM_CNT; lg_i = SRAM_LG; end
      default: ;
    endcase
    spp_i   = 1 << lg_i;
    start_i = int'(map_start[15:8]);
    nsl_i   = int'(map_end[15:8]) - start_i + 1;
    limit_i = (nsl_i < spp_i) ? nsl_i : ((nsl_i >> lg_i) << lg_i);
    if (cnt_i == 0)       p0 = 0;
    else if (map_page < 0) p0 = cnt_i + int'(map_page);
    else                  p0 = int'(map_page) % cnt_i;
    acc_w  = map_dflt ? dflt_acc : map_acc;
    ok_req = map_we && (map_start[7:0] == 8'h00) && (map_end[7:0] == 8'hFF) &&
             (map_start <= 16'hFF00) && (map_end > map_start) &&
             (map_type != 2'd3) && (cnt_i != 0);
  end

  always_comb begin
    for (int i = 0; i < 256; i++) begin
      n_hit[i] = 1'b0;
      n_off[i] = '0;
      if (ok_req && (i >= start_i) && ((i - start_i) < limit_i)) begin
        n_hit[i] = 1'b1;
        n_off[i] = OFF_W'(((p0 + ((i - start_i) >> lg_i)) % cnt_i) * spp_i +
                          ((i - start_i) & (spp_i - 1)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin
        if (RST_EN && (i >= 96) && (i < 128)) begin
          t_type[i] <= RST_TYPE;
          t_acc[i]  <= ACC_RW;
          t_off[i]  <= OFF_W'((i - 96) % RST_SL);
        end else begin
          t_type[i] <= 2'd0;
          t_acc[i]  <= ACC_NONE;
          t_off[i]  <= '0;
        end
      end
    end else begin
      for (int i = 0; i < 256; i++) begin
        if (n_hit[i]) begin
          t_type[i] <= map_type;
          t_acc[i]  <= acc_w;
          t_off[i]  <= n_off[i];
        end
      end
    end
  end

  logic [7:0]       slot;
  logic [1:0]       c_type, c_acc;
  logic [OFF_W+7:0] byte_off;
  logic [7:0]       src_byte, slot_byte, open_q;
  logic             in_reg;

  assign slot     = cpu_addr[15:8];
  assign c_type   = t_type[slot];
  assign c_acc    = t_acc[slot];
  assign byte_off = {t_off[slot], cpu_addr[7:0]};

  assign rom_addr  = byte_off[ROM_AW-1:0];
  assign wram_addr = byte_off[WRAM_AW-1:0];
  assign sram_addr = byte_off[SRAM_AW-1:0];

  always_comb begin
    case (c_type)
      2'd0:    src_byte = rom_rdata;
      2'd1:    src_byte = wram_rdata;
      2'd2:    src_byte = sram_rdata;
      default: src_byte = 8'hFF;
    endcase
  end

  assign slot_byte = c_acc[0] ? src_byte : 8'hFF;
  assign in_reg    = (cpu_addr >= REG_LO) && (cpu_addr <= REG_HI);

  assign reg_rd       = cpu_rd && cfg_reg_read && in_reg;
  assign reg_wr       = cpu_wr && in_reg;
  assign reg_wdata    = cfg_bus_conflict ? (cpu_wdata & slot_byte) : cpu_wdata;
  assign bus_conflict = reg_wr && cfg_bus_conflict && (cpu_wdata != slot_byte);

  assign cpu_rdata = reg_rd ? reg_rdata : (c_acc[0] ? src_byte : open_q);

  assign wram_wdata = cpu_wdata;
  assign sram_wdata = cpu_wdata;
  assign wram_we = cpu_wr && !in_reg && c_acc[1] && (c_type == 2'd1);
  assign sram_we = cpu_wr && !in_reg && c_acc[1] && (c_type == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n)      open_q <= 8'h00;
    else if (cpu_rd) open_q <= cpu_rdata;
    else if (cpu_wr) open_q <= cpu_wdata;
  end

endmodule

// File: rtl/cpu_bank_map_chk.sv
module cpu_bank_map_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cpu_rd,
  input logic       cpu_wr,
  input logic [7:0] cpu_wdata,
  input logic [7:0] cpu_rdata,
  input logic       cfg_bus_conflict,
  input logic       cfg_reg_read,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic [7:0] reg_rdata,
  input logic       bus_conflict,
  input logic       wram_we,
  input logic       sram_we
);

  // R7
  ram_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wram_we, sram_we}));

  // R7
  wram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_wr && !reg_wr));

  // R7
  sram_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sram_we |-> (cpu_wr && !reg_wr));

  // R8
  conflict_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_conflict |-> (reg_wr && cfg_bus_conflict));

  // R8
  and_only_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> ((reg_wdata & ~cpu_wdata) == 8'h00));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !cfg_bus_conflict) |-> (reg_wdata == cpu_wdata));

  // R9
  reg_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (cpu_rd && cfg_reg_read && (cpu_rdata == reg_rdata)));

endmodule

bind cpu_bank_map cpu_bank_map_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
  .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
  .cfg_bus_conflict(cfg_bus_conflict), .cfg_reg_read(cfg_reg_read),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_conflict(bus_conflict), .wram_we(wram_we), .sram_we(sram_we)
);

// File: tb/cpu_bank_map_test.sv
`timescale 1ns/1ps
module cpu_bank_map_test;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_rd, cpu_wr;
  logic [7:0]  cpu_wdata;
  logic [7:0]  cpu_rdata, cpu_rdata_s;
  logic        cfg_bus_conflict, cfg_reg_read;
  logic        reg_rd, reg_wr, bus_conflict;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        map_we, map_dflt;
  logic [15:0] map_start, map_end;
  logic [1:0]  map_type, map_acc;
  logic signed [7:0] map_page;
  logic [15:0] rom_addr;
  logic [7:0]  rom_rdata;
  logic [12:0] wram_addr;
  logic [7:0]  wram_wdata, wram_rdata;
  logic        wram_we;
  logic [14:0] sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        sram_we;

  logic        s_reg_rd, s_reg_wr, s_conf, s_wwe, s_swe;
  logic [7:0]  s_reg_wdata, s_wwd, s_swd;
  logic [11:0] s_rom_addr;
  logic [7:0]  s_rom_rdata;
  logic [12:0] s_waddr;
  logic [14:0] s_saddr;

  logic [7:0] wram_m [8192];
  logic [7:0] sram_m [24576];

  function automatic logic [7:0] rom_byte(input int a);
    return 8'(((a * 37) ^ ((a >> 8) * 11 + 5)) & 255);
  endfunction

  assign rom_rdata   = rom_byte(int'(rom_addr));
  assign s_rom_rdata = rom_byte(int'(s_rom_addr));
  assign wram_rdata  = wram_m[wram_addr];
  assign sram_rdata  = sram_m[sram_addr];
  assign reg_rdata   = 8'hC3;

  always @(posedge clk) begin
    if (wram_we) wram_m[wram_addr] <= wram_wdata;
    if (sram_we) sram_m[sram_addr] <= sram_wdata;
  end

  cpu_bank_map uut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cfg_bus_conflict(cfg_bus_conflict), .cfg_reg_read(cfg_reg_read),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bus_conflict(bus_conflict),
    .map_we(map_we), .map_start(map_start), .map_end(map_end), .map_type(map_type),
    .map_page(map_page), .map_dflt(map_dflt), .map_acc(map_acc),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .wram_addr(wram_addr), .wram_wdata(wram_wdata), .wram_we(wram_we), .wram_rdata(wram_rdata),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_we(sram_we), .sram_rdata(sram_rdata)
  );

  cpu_bank_map #(.ROM_BYTES(4096), .ROM_PAGE(16384)) uut_mir (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata_s),
    .cfg_bus_conflict(cfg_bus_conflict), .cfg_reg_read(cfg_reg_read),
    .reg_rd(s_reg_rd), .reg_wr(s_reg_wr), .reg_wdata(s_reg_wdata), .reg_rdata(reg_rdata),
    .bus_conflict(s_conf),
    .map_we(map_we), .map_start(map_start), .map_end(map_end), .map_type(map_type),
    .map_page(map_page), .map_dflt(map_dflt), .map_acc(map_acc),
    .rom_addr(s_rom_addr), .rom_rdata(s_rom_rdata),
    .wram_addr(s_waddr), .wram_wdata(s_wwd), .wram_we(s_wwe), .wram_rdata(8'h00),
    .sram_addr(s_saddr), .sram_wdata(s_swd), .sram_we(s_swe), .sram_rdata(8'h00)
  );

  int total = 0;
  int bad = 0;
  int m_type [256];
  int m_acc  [256];
  int m_off  [256];
  logic [7:0] ob;

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_src(input int s, input int lo);
    int idx;
    idx = m_off[s] * 256 + lo;
    case (m_type[s])
      0: return rom_byte(idx);
      1: return wram_m[idx];
      2: return sram_m[idx];
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] model_read(input int a);
    int s;
    s = a >> 8;
    if (cfg_reg_read && a >= 'h8000) return 8'hC3;
    if ((m_acc[s] & 1) != 0) return model_src(s, a & 255);
    return ob;
  endfunction

  task automatic model_map(input int s, input int e, input int t, input int pg,
                           input bit dflt, input int acc);
    int cnt, spp, n, p, a, b;
    spp = 32;
    cnt = (t == 0) ? 5 : (t == 1) ? 1 : (t == 2) ? 3 : 0;
    if ((s & 255) != 0 || (e & 255) != 255 || s > 'hFF00 || e <= s || cnt == 0) return;
    a = dflt ? ((t == 0) ? 1 : 3) : acc;
    p = (pg < 0) ? cnt + pg : pg % cnt;
    n = (e >> 8) - (s >> 8) + 1;
    b = s >> 8;
    if (n < spp) begin
      for (int r = 0; r < n; r++) begin
        m_type[b + r] = t; m_acc[b + r] = a; m_off[b + r] = p * spp + r;
      end
    end else begin
      for (int k = 0; (k + 1) * spp <= n; k++) begin
        for (int r = 0; r < spp; r++) begin
          m_type[b + k * spp + r] = t; m_acc[b + k * spp + r] = a;
          m_off[b + k * spp + r] = p * spp + r;
        end
        p = (p + 1) % cnt;
      end
    end
  endtask

  task automatic do_map(input int s, input int e, input int t, input int pg,
                        input bit dflt, input int acc);
    @(negedge clk);
    map_start = 16'(s); map_end = 16'(e); map_type = 2'(t);
    map_page = 8'(pg); map_dflt = dflt; map_acc = 2'(acc); map_we = 1'b1;
    @(posedge clk);
    #1 map_we = 1'b0;
    model_map(s, e, t, pg, dflt, acc);
  endtask

  task automatic do_read(input int a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_rd = 1'b1;
    #1;
    e = model_read(a);
    chk(int'(cpu_rdata), int'(e), tag);
    ob = e;
    @(posedge clk);
    #1 cpu_rd = 1'b0;
  endtask

  task automatic do_write(input int a, input logic [7:0] d, input string tag);
    int s, lo;
    bit inr, ewe, ese;
    logic [7:0] mb;
    s = a >> 8; lo = a & 255;
    @(negedge clk);
    cpu_addr = 16'(a); cpu_wdata = d; cpu_wr = 1'b1;
    #1;
    inr = (a >= 'h8000);
    mb  = ((m_acc[s] & 1) != 0) ? model_src(s, lo) : 8'hFF;
    ewe = !inr && (m_acc[s] & 2) != 0 && m_type[s] == 1;
    ese = !inr && (m_acc[s] & 2) != 0 && m_type[s] == 2;
    chk(int'(reg_wr), int'(inr), {tag, " reg_wr"});
    chk(int'(wram_we), int'(ewe), {tag, " wram_we"});
    chk(int'(sram_we), int'(ese), {tag, " sram_we"});
    if (inr) begin
      chk(int'(reg_wdata), cfg_bus_conflict ? int'(d & mb) : int'(d), {tag, " reg_wdata"});
      chk(int'(bus_conflict), int'(cfg_bus_conflict && d != mb), {tag, " bus_conflict"});
    end
    if (ewe) chk(int'(wram_addr), (m_off[s] * 256 + lo) & 8191, {tag, " wram_addr"});
    if (ese) chk(int'(sram_addr), m_off[s] * 256 + lo, {tag, " sram_addr"});
    ob = d;
    @(posedge clk);
    #1 cpu_wr = 1'b0;
  endtask

  task automatic sweep_read(input string tag);
    for (int s = 0; s < 256; s++) do_read(s * 256 + ((s * 29 + 3) & 255), tag);
  endtask

  task automatic sweep_write(input string tag);
    for (int s = 0; s < 256; s++)
      do_write(s * 256 + ((s * 53 + 17) & 255), 8'((s * 7) ^ 8'h3C), tag);
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8192; i++) wram_m[i] = 8'((i * 3 + 1) & 255);
    for (int i = 0; i < 24576; i++) sram_m[i] = 8'((i * 5 + 7) ^ (i >> 8));
    for (int i = 0; i < 256; i++) begin
      m_type[i] = (i >= 96 && i < 128) ? 2 : 0;
      m_acc[i]  = (i >= 96 && i < 128) ? 3 : 0;
      m_off[i]  = (i >= 96 && i < 128) ? i - 96 : 0;
    end
    ob = 8'h00;
    rst_n = 1'b0; cpu_addr = '0; cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    cfg_bus_conflict = 1'b0; cfg_reg_read = 1'b0;
    map_we = 1'b0; map_start = '0; map_end = '0; map_type = '0; map_page = '0;
    map_dflt = 1'b1; map_acc = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R11 reset map, R6 open bus on unmapped slots, R1 reads
    sweep_read("R11");
    // R4 full range with page wrap, R5 ROM default read-only
    do_map('h8000, 'hFFFF, 0, 3, 1'b1, 0);
    sweep_read("R4");
    // R3 negative page and modulo of a non power of two count
    do_map('hC000, 'hDFFF, 0, -2, 1'b1, 0);
    sweep_read("R3 neg");
    do_map('hA000, 'hBFFF, 0, 7, 1'b1, 0);
    sweep_read("R3 mod");
    // R2 malformed requests leave the table alone
    do_map('h9010, 'h9FFF, 1, 0, 1'b1, 0);
    do_map('h9000, 'h9FFE, 1, 0, 1'b1, 0);
    do_map('hF000, 'hEFFF, 1, 0, 1'b1, 0);
    do_map('h9000, 'h9FFF, 3, 0, 1'b1, 0);
    sweep_read("R2");
    // R4 short range, R5 RAM default read/write, R7 writes
    do_map('h5000, 'h5FFF, 1, 0, 1'b1, 0);
    sweep_write("R7");
    sweep_read("R1");
    // R5 explicit read-only RAM and default ROM below the register window
    do_map('h6000, 'h63FF, 2, 0, 1'b0, 1);
    do_map('h2000, 'h3FFF, 0, 4, 1'b1, 0);
    sweep_write("R5");
    sweep_read("R5");
    // R4 trailing partial page left untouched
    do_map('h0000, 'h2FFF, 2, 1, 1'b1, 0);
    sweep_read("R4 tail");
    // R8 bus conflicts
    cfg_bus_conflict = 1'b1;
    do_map('hE000, 'hE0FF, 0, 0, 1'b0, 0);
    sweep_write("R8");
    do_write('hE012, 8'hFF, "R8 unreadable");
    do_write('hE013, 8'h5A, "R8 unreadable");
    cfg_bus_conflict = 1'b0;
    // R9 register reads
    cfg_reg_read = 1'b1;
    sweep_read("R9");
    cfg_reg_read = 1'b0;
    sweep_read("R9 off");
    // R6 last write data seen on an unmapped read
    do_write('h4100, 8'h5E, "R6");
    do_read('h4177, "R6");
    // R12 same-cycle access sees the old map
    @(negedge clk);
    map_start = 16'h4000; map_end = 16'h40FF; map_type = 2'd1; map_page = 8'sd0;
    map_dflt = 1'b1; map_we = 1'b1; cpu_addr = 16'h4010; cpu_rd = 1'b1;
    #1;
    chk(int'(cpu_rdata), int'(ob), "R12 old");
    @(posedge clk);
    #1 map_we = 1'b0; cpu_rd = 1'b0;
    model_map('h4000, 'h40FF, 1, 0, 1'b1, 0);
    do_read('h4010, "R12 new");
    // R10 small ROM repeats across 0x8000-0xFFFF
    do_map('h8000, 'hFFFF, 0, 0, 1'b1, 0);
    for (int s = 128; s < 256; s++) begin
      @(negedge clk);
      cpu_addr = 16'(s * 256 + ((s * 13) & 255)); cpu_rd = 1'b1;
      #1;
      chk(int'(cpu_rdata_s), int'(rom_byte(((s - 128) % 16) * 256 + ((s * 13) & 255))), "R10");
      ob = model_read(s * 256 + ((s * 13) & 255));
      @(posedge clk);
      #1 cpu_rd = 1'b0;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule